// File: doc/BRIEF.md
# Timer time-base with update control

This block is a 16-bit counter driven through a prescaler. It has one compare channel. It counts up or down with a wrap at the auto-reload value, or it counts up and down between zero and that value in one of three center-aligned modes. A small register write port loads three values ahead of time: the auto-reload limit, the prescaler divisor and the compare value. They are copied into the working (shadow) registers only when an update event takes place. The same port sets the control bits.

Update events come from three sources: a counter wrap, a software update strobe and a slave reset strobe. A control bit narrows the set of events that may raise the update request pulse. A second bit suppresses update events altogether. While events are suppressed, the shadow registers keep their values, but either strobe still restarts the counter and the prescaler. The counter can also be started by a trigger input, and a one-shot mode stops it at the next update event.

The write port is a plain single-cycle strobe with no back-pressure. Every write is accepted in the cycle it is presented. The update request and the compare flag are one-cycle pulses with no handshake.

Top module: `tmr_timebase`

## Requirements
- R1: After reset the counter reads 0, the direction status reads 0 (up), and neither the update request nor the compare flag is asserted.
- R2: Write addresses are 0 for control, 1 for the auto-reload preload, 2 for the prescaler preload and 3 for the compare preload. In edge mode (mode field 0) with direction 0, the counter steps 0,1,...,A and then wraps to 0, where A is the shadow auto-reload. The wrap step raises the update request in the following cycle.
- R3: In edge mode with direction bit 1, the counter steps down from A to 0 and then reloads A. The reload is an underflow that raises the update request. The direction status reads 1.
- R4: With shadow prescaler value P, the counter takes one step every P+1 enabled clock cycles. Preload values reach the shadow registers only through an update event.
- R5: Control bits: bit 0 run, bit 1 update off, bit 2 wrap-only request, bit 3 one-shot, bit 4 direction, bits 6:5 mode, bit 7 trigger start. Any nonzero mode counts 0 up to A and back down to 0, reversing at each end. Leaving the top or the bottom is a wrap. In these modes the direction status shows the hardware direction, and writes to bit 4 are ignored.
- R6: The compare flag pulses on a step that lands on the shadow compare value. In mode 1 only down-steps qualify, in mode 2 only up-steps qualify, and in modes 3 and 0 both directions qualify.
- R7: A control write that moves the mode from 0 to a nonzero value while run is 1 leaves the mode unchanged. The other fields of that write still take effect.
- R8: With one-shot set, an update event clears run and the counter stops at the value it reached.
- R9: With bit 2 at 0, a wrap, a software update strobe or a slave reset raises the update request. With bit 2 at 1, only a wrap raises it, although the strobes still load the shadows.
- R10: With update off set, no update request is raised and the shadow registers keep their values, including across wraps.
- R11: A software update strobe or a slave reset clears the prescaler count. It sets the counter to A when counting down in edge mode and to 0 in all other cases, and center modes restart counting up. This happens even while update off is set.
- R12: The slave trigger input sets run only while the trigger start bit is 1. A stopped counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write value |
| sw_update | input | 1 | Software update strobe |
| slv_reset | input | 1 | Slave-mode reset strobe |
| slv_trig | input | 1 | Slave-mode trigger input |
| cnt_value | output | 16 | Current counter value |
| dir_status | output | 1 | Counting direction, 1 = down |
| upd_req | output | 1 | Update interrupt/DMA request pulse |
| cmp_flag | output | 1 | Compare match pulse |

## Verification
The bench walks full periods in every counting mode. It checks the turnaround points in the center modes, where a design that reused the direction bit, or that fired the wrap on arrival instead of on departure, would shift the update pulse by a step or follow the wrong sequence. It checks that the compare flag appears only on the qualified half of each center period, so a design that ignores the mode would raise it twice. It exercises the filtering and suppression of update events, where a leaky design would pulse the request on a strobe or load a new limit that changes the wrap point. It also tries a direction write in center mode and an edge-to-center switch while running, either of which would visibly alter the count sequence or the direction status if accepted.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_EDGE  = 2'd0,
    MODE_CDN   = 2'd1,
    MODE_CUP   = 2'd2,
    MODE_CBOTH = 2'd3
  } tmr_mode_e;

  localparam int ADR_CTRL = 0;
  localparam int ADR_ARR  = 1;
  localparam int ADR_PSC  = 2;
  localparam int ADR_CMP  = 3;

  localparam int BIT_RUN  = 0;
  localparam int BIT_UOFF = 1;
  localparam int BIT_WRAP = 2;
  localparam int BIT_ONE  = 3;
  localparam int BIT_DIR  = 4;
  localparam int BIT_MODE = 5;
  localparam int BIT_TRG  = 7;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          sw_update,
  input  logic          slv_reset,
  input  logic          slv_trig,
  input  logic          wrap_ev,
  output logic          run,
  output tmr_mode_e     mode,
  output logic          dir_bit,
  output logic [CW-1:0] arr_sh,
  output logic [CW-1:0] psc_sh,
  output logic [CW-1:0] cmp_sh,
  output logic [CW-1:0] arr_next,
  output logic          reinit,
  output logic          upd_req
);
  logic          run_q, run_d, uoff_q, wrap_only_q, one_q, dir_q, trg_q;
  tmr_mode_e     mode_q, mode_wr;
  logic [CW-1:0] arr_pre, psc_pre, cmp_pre, arr_q, psc_q, cmp_q;
  logic          ctrl_wr, uev, upd_q;

  assign ctrl_wr  = wr_en && (wr_addr == AW'(ADR_CTRL));
  assign mode_wr  = tmr_mode_e'(wr_data[BIT_MODE +: 2]);
  assign reinit   = sw_update | slv_reset;
  assign uev      = !uoff_q && (wrap_ev || reinit);
  assign arr_next = uev ? arr_pre : arr_q;

  // run: software write, then trigger start, then one-shot stop (highest)
  always_comb begin
    run_d = run_q;
    if (ctrl_wr)              run_d = wr_data[BIT_RUN];
    if (trg_q && slv_trig)    run_d = 1'b1;
    if (one_q && uev)         run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      uoff_q      <= 1'b0;
      wrap_only_q <= 1'b0;
      one_q       <= 1'b0;
      dir_q       <= 1'b0;
      trg_q       <= 1'b0;
      mode_q      <= MODE_EDGE;
    end else begin
      run_q <= run_d;
      if (ctrl_wr) begin
        uoff_q      <= wr_data[BIT_UOFF];
        wrap_only_q <= wr_data[BIT_WRAP];
        one_q       <= wr_data[BIT_ONE];
        trg_q       <= wr_data[BIT_TRG];
        if (mode_q == MODE_EDGE) dir_q <= wr_data[BIT_DIR];
        if (!(run_q && mode_q == MODE_EDGE && mode_wr != MODE_EDGE))
          mode_q <= mode_wr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_pre <= '0;
      psc_pre <= '0;
      cmp_pre <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADR_ARR)) arr_pre <= wr_data;
      if (wr_addr == AW'(ADR_PSC)) psc_pre <= wr_data;
      if (wr_addr == AW'(ADR_CMP)) cmp_pre <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_q <= '0;
      psc_q <= '0;
      cmp_q <= '0;
      upd_q <= 1'b0;
    end else begin
      if (uev) begin
        arr_q <= arr_pre;
        psc_q <= psc_pre;
        cmp_q <= cmp_pre;
      end
      upd_q <= uev && (!wrap_only_q || wrap_ev);
    end
  end

  assign run     = run_q;
  assign mode    = mode_q;
  assign dir_bit = dir_q;
  assign arr_sh  = arr_q;
  assign psc_sh  = psc_q;
  assign cmp_sh  = cmp_q;
  assign upd_req = upd_q;

  p_shadow_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uoff_q |=> ($stable(arr_q) && $stable(psc_q) && $stable(cmp_q)));

  p_wrap_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_only_q && !wrap_ev) |=> !upd_q);

  p_one_shot_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (one_q && wrap_ev && !uoff_q) |=> !run_q);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          reinit,
  input  logic [CW-1:0] psc_sh,
  output logic          tick
);
  logic [CW-1:0] div_q;

  assign tick = run && !reinit && (div_q >= psc_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (reinit) div_q <= '0;
    else if (run)    div_q <= tick ? '0 : div_q + CW'(1);
  end

  p_restart_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> !tick || (psc_sh == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          reinit,
  input  tmr_mode_e     mode,
  input  logic          dir_bit,
  input  logic [CW-1:0] arr_sh,
  input  logic [CW-1:0] arr_next,
  input  logic [CW-1:0] cmp_sh,
  output logic [CW-1:0] cnt,
  output logic          dir_status,
  output logic          wrap_ev,
  output logic          cmp_flag
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hw_down_q, hw_down_d, up_step, qual, cmp_q;
  logic          center;

  assign center = (mode != MODE_EDGE);

  always_comb begin
    wrap_ev = 1'b0;
    if (step) begin
      if (center ? hw_down_q : dir_bit) wrap_ev = (cnt_q == '0);
      else                              wrap_ev = (cnt_q >= arr_sh);
    end
  end

  always_comb begin
    cnt_d     = cnt_q;
    hw_down_d = center ? hw_down_q : 1'b0;
    up_step   = 1'b1;
    if (reinit) begin
      cnt_d     = (!center && dir_bit) ? arr_next : '0;
      hw_down_d = 1'b0;
    end else if (step) begin
      if (!center) begin
        if (dir_bit) begin
          up_step = 1'b0;
          cnt_d   = (cnt_q == '0) ? arr_next : cnt_q - CW'(1);
        end else begin
          cnt_d   = (cnt_q >= arr_sh) ? '0 : cnt_q + CW'(1);
        end
      end else if (!hw_down_q) begin
        if (cnt_q >= arr_sh) begin
          hw_down_d = 1'b1;
          up_step   = 1'b0;
          cnt_d     = (arr_sh == '0) ? '0 : arr_sh - CW'(1);
        end else begin
          cnt_d     = cnt_q + CW'(1);
        end
      end else begin
        if (cnt_q == '0) begin
          hw_down_d = 1'b0;
          cnt_d     = (arr_sh == '0) ? '0 : CW'(1);
        end else begin
          up_step   = 1'b0;
          cnt_d     = cnt_q - CW'(1);
        end
      end
    end
  end

  always_comb begin
    case (mode)
      MODE_CDN: qual = !up_step;
      MODE_CUP: qual = up_step;
      default:  qual = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      hw_down_q <= 1'b0;
      cmp_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      hw_down_q <= hw_down_d;
      cmp_q     <= step && !reinit && qual && (cnt_d == cmp_sh);
    end
  end

  assign cnt        = cnt_q;
  assign cmp_flag   = cmp_q;
  assign dir_status = center ? hw_down_q : dir_bit;

  p_top_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (center && !hw_down_q && step && !reinit && (cnt_q >= arr_sh) && (arr_sh != '0))
      |=> hw_down_q);
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          sw_update,
  input  logic          slv_reset,
  input  logic          slv_trig,
  output logic [CW-1:0] cnt_value,
  output logic          dir_status,
  output logic          upd_req,
  output logic          cmp_flag
);
  logic          run, dir_bit, reinit, tick, wrap_ev;
  tmr_mode_e     mode;
  logic [CW-1:0] arr_sh, psc_sh, cmp_sh, arr_next;

  tmr_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sw_update(sw_update), .slv_reset(slv_reset), .slv_trig(slv_trig),
    .wrap_ev(wrap_ev), .run(run), .mode(mode), .dir_bit(dir_bit),
    .arr_sh(arr_sh), .psc_sh(psc_sh), .cmp_sh(cmp_sh), .arr_next(arr_next),
    .reinit(reinit), .upd_req(upd_req)
  );

  tmr_prescaler #(.CW(CW)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .reinit(reinit), .psc_sh(psc_sh),
    .tick(tick)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(tick), .reinit(reinit), .mode(mode),
    .dir_bit(dir_bit), .arr_sh(arr_sh), .arr_next(arr_next), .cmp_sh(cmp_sh),
    .cnt(cnt_value), .dir_status(dir_status), .wrap_ev(wrap_ev),
    .cmp_flag(cmp_flag)
  );

  p_idle_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reinit) |=> $stable(cnt_value));
endmodule

// File: tb/test_tmr_timebase.sv
module test_tmr_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        sw_update = 1'b0, slv_reset = 1'b0, slv_trig = 1'b0;
  logic [15:0] cnt_value;
  logic        dir_status, upd_req, cmp_flag;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  tmr_timebase i_tmr_timebase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sw_update(sw_update), .slv_reset(slv_reset), .slv_trig(slv_trig),
    .cnt_value(cnt_value), .dir_status(dir_status), .upd_req(upd_req),
    .cmp_flag(cmp_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // all stimulus tasks start and end at a falling edge
  task automatic wr(input int addr, input int data);
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_ug();
    sw_update = 1'b1; @(negedge clk); sw_update = 1'b0;
  endtask

  task automatic pulse_slv();
    slv_reset = 1'b1; @(negedge clk); slv_reset = 1'b0;
  endtask

  task automatic pulse_trig();
    slv_trig = 1'b1; @(negedge clk); slv_trig = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", int'(cnt_value), 0);
    chk("R1 dir", int'(dir_status), 0);
    chk("R1 upd", int'(upd_req), 0);
    chk("R1 cmp", int'(cmp_flag), 0);
  endtask

  task automatic t_edge_up();
    wr(1, 4); wr(2, 0); wr(3, 2);
    pulse_ug();
    chk("R9 sw strobe request", int'(upd_req), 1);
    chk("R11 restart up", int'(cnt_value), 0);
    wr(0, 1);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chk("R2 up count", int'(cnt_value), k % 5);
      chk("R2 overflow request", int'(upd_req), int'(k % 5 == 0));
      chk("R6 edge compare", int'(cmp_flag), int'(k % 5 == 2));
    end
  endtask

  task automatic t_prescale();
    wr(0, 0); wr(2, 2);
    pulse_ug();
    wr(0, 1);
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      chk("R4 divide by 3", int'(cnt_value), k / 3);
    end
  endtask

  task automatic t_edge_down();
    wr(0, 0); wr(2, 0); wr(0, 1 << 4);
    pulse_ug();
    chk("R11 restart down", int'(cnt_value), 4);
    wr(0, (1 << 4) | 1);
    for (int k = 1; k <= 10; k++) begin
      int e;
      @(negedge clk);
      e = (4 - (k % 5) + 5) % 5;
      chk("R3 down count", int'(cnt_value), e);
      chk("R3 underflow request", int'(upd_req), int'(e == 4));
      chk("R3 dir status", int'(dir_status), 1);
      chk("R6 edge compare down", int'(cmp_flag), int'(e == 2));
    end
  endtask

  task automatic run_center(input int m);
    wr(0, 0); wr(0, m << 5);
    pulse_ug();
    wr(0, (m << 5) | 1);
    for (int k = 1; k <= 16; k++) begin
      int pos, e, ec;
      @(negedge clk);
      pos = k % 8;
      e   = (pos <= 4) ? pos : 8 - pos;
      case (m)
        1:       ec = int'(pos == 6);
        2:       ec = int'(pos == 2);
        default: ec = int'(pos == 2 || pos == 6);
      endcase
      chk("R5 center count", int'(cnt_value), e);
      chk("R5 center wrap request", int'(upd_req), int'(pos == 5 || (pos == 1 && k > 1)));
      chk("R5 hw direction", int'(dir_status), int'(pos >= 5 || pos == 0));
      chk("R6 qualified compare", int'(cmp_flag), ec);
    end
  endtask

  task automatic t_dir_locked();
    wr(0, 3 << 5);
    pulse_ug();
    wr(0, (3 << 5) | (1 << 4));
    chk("R5 dir write ignored center", int'(dir_status), 0);
    wr(0, 1 << 4);
    chk("R5 dir ignored on leaving center", int'(dir_status), 0);
    wr(0, 1 << 4);
    chk("R5 dir accepted in edge", int'(dir_status), 1);
    wr(0, 0);
  endtask

  task automatic t_mode_lock();
    int c0;
    pulse_ug();
    wr(0, 1);
    wr(0, (3 << 5) | 1);
    c0 = int'(cnt_value);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R7 mode switch ignored", int'(cnt_value), (c0 + k) % 5);
      chk("R7 still edge dir", int'(dir_status), 0);
    end
  endtask

  task automatic t_one_shot();
    wr(0, 0);
    pulse_ug();
    wr(0, (1 << 3) | 1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R8 one-shot count", int'(cnt_value), (k < 5) ? k : 0);
      chk("R8 one-shot request", int'(upd_req), int'(k == 5));
    end
  endtask

  task automatic t_req_source();
    wr(0, 1 << 2); wr(1, 2);
    pulse_ug();
    chk("R9 strobe filtered", int'(upd_req), 0);
    wr(0, (1 << 2) | 1);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R9 shadow loaded silently", int'(cnt_value), k % 3);
      chk("R9 wrap passes filter", int'(upd_req), int'(k % 3 == 0));
    end
    wr(0, 0);
    pulse_slv();
    chk("R9 slave reset request", int'(upd_req), 1);
  endtask

  task automatic t_update_off();
    wr(1, 6);
    wr(0, (1 << 1) | 1);
    @(negedge clk);
    pulse_ug();
    chk("R11 restart while off", int'(cnt_value), 0);
    chk("R10 no request on strobe", int'(upd_req), 0);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      chk("R10 limit frozen", int'(cnt_value), k % 3);
      chk("R10 no request on wrap", int'(upd_req), 0);
    end
    pulse_slv();
    chk("R11 slave restart while off", int'(cnt_value), 0);
    chk("R10 no request on slave", int'(upd_req), 0);
  endtask

  task automatic t_trigger();
    wr(0, 0);
    pulse_ug();
    pulse_trig();
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R12 trigger ignored", int'(cnt_value), 0);
    end
    wr(0, 1 << 7);
    @(negedge clk);
    chk("R12 armed idle", int'(cnt_value), 0);
    pulse_trig();
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R12 trigger start", int'(cnt_value), k);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge_up();
    t_prescale();
    t_edge_down();
    run_center(3);
    run_center(2);
    run_center(1);
    t_dir_locked();
    t_mode_lock();
    t_one_shot();
    t_req_source();
    t_update_off();
    t_trigger();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule